// File: doc/BRIEF.md
# Pattern-Driven Detector Clock Sequencer

This block produces a set of detector clock waveforms by stepping through state words held in an on-chip pattern memory. Each state word sets the level of every clock line and says how long that level set is held. A second, smaller memory holds the sequence program. Each program entry names the pattern to play by its first address. It also gives a read-speed factor that stretches every state of that pattern, and a repeat count. A pattern runs from its start address until it meets a state whose end-of-pattern bit is set. It is then replayed as many extra times as the repeat count asks, and the controller fetches the next program entry.

A host loads both memories while the block is idle. A single-cycle start pulse then begins execution at program address 0. The busy output stays high until a program entry with its stop bit set is reached, or until the host pulses abort. In both cases the clock lines keep the last levels they were driven to.

Top module: `clkseq_top`

## Requirements
- R1: While reset is high and after it is released, `clk_lines` is all zeros and `busy` is low until the first start.
- R2: A start pulse while idle raises `busy` after the next edge, which is the fetch cycle of program address 0. The first state's levels appear after the edge that follows.
- R3: A pattern word is {eop[26], dwell[25:18], levels[17:0]}. Its levels are held for exactly (dwell+1)×(rsp+1) clock cycles, where rsp is the read-speed field of the running program entry.
- R4: A program word is {stop[18], rsp[17:14], rep[13:6], start[5:0]}. The pattern is played rep+1 times back to back, and the first state of a repeat follows the end-of-pattern state with no gap.
- R5: Within a pattern, states are taken from consecutive addresses, starting at the start address and ending with the first state whose eop bit is set. A state whose eop bit is set at the start address forms a one-state pattern.
- R6: After the final repetition, the last state is held for one extra fetch cycle. The next program entry, taken from the following program address, then begins.
- R7: A program entry with stop set drops `busy` after its fetch cycle, and `clk_lines` keeps its last value.
- R8: An abort pulse while busy drops `busy` after the next edge, and `clk_lines` keeps the value it had when abort was sampled.
- R9: Writes to either memory while `busy` is high are ignored. Writes while idle take effect for the next run.
- R10: A start pulse while busy has no effect on the running program.
- R11: `clk_lines` never changes while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Start pulse, begins the program at address 0 when idle |
| run_abort | input | 1 | Abort pulse, ends a running program at once |
| pat_wr_en | input | 1 | Pattern memory write enable |
| pat_wr_addr | input | 6 | Pattern memory write address |
| pat_wr_data | input | 27 | Pattern state word |
| seq_wr_en | input | 1 | Program memory write enable |
| seq_wr_addr | input | 4 | Program memory write address |
| seq_wr_data | input | 19 | Program entry word |
| clk_lines | output | 18 | Detector clock levels |
| busy | output | 1 | High while a program runs |

## Verification
The assertions check on every cycle the properties that involve only a single edge. Clock lines are frozen whenever the block is idle or a state's dwell has not expired. Start raises busy, abort drops busy with the levels held, and the levels are held when busy falls. The exact dwell length, the repeat count, the address order within a pattern and the extra cycle at an instruction boundary can only be shown by the bench. It sweeps read speed and repeat count over a small pattern set and compares every output cycle against a trace computed from the programmed words. The bench also runs multi-entry programs, a one-state pattern, a maximum-dwell state, a stop at address 0, abort, and writes or start pulses issued while the block is busy.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    localparam int NCLK   = 18;
    localparam int DW_W   = 8;
    localparam int PAT_AW = 6;
    localparam int SEQ_AW = 4;
    localparam int RSP_W  = 4;
    localparam int REP_W  = 8;

    typedef struct packed {
        logic              eop;
        logic [DW_W-1:0]   dwell;
        logic [NCLK-1:0]   lv;
    } pat_word_t;

    typedef struct packed {
        logic              stop;
        logic [RSP_W-1:0]  rsp;
        logic [REP_W-1:0]  rep;
        logic [PAT_AW-1:0] start;
    } seq_word_t;

    localparam int PAT_W = $bits(pat_word_t);
    localparam int SEQ_W = $bits(seq_word_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PLAY  = 2'd2
    } run_state_t;

    // Address of the state that follows the current one: restart at the
    // pattern start after an end-of-pattern state, otherwise step by one.
    function automatic logic [PAT_AW-1:0] follow_addr(
        input logic              at_eop,
        input logic [PAT_AW-1:0] cur,
        input logic [PAT_AW-1:0] first
    );
        return at_eop ? first : cur + 1'b1;
    endfunction

endpackage

// File: rtl/clkseq_mem.sv
module clkseq_mem #(
    parameter int AW = 6,
    parameter int W  = 27
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/clkseq_dwell.sv
module clkseq_dwell #(
    parameter int DW_W  = 8,
    parameter int RSP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DW_W-1:0]  dwell_in,
    input  logic [RSP_W-1:0] rsp_in,
    output logic             last
);
    logic [DW_W-1:0]  dcnt;
    logic [RSP_W-1:0] rcnt;
    logic [RSP_W-1:0] rreload;

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt    <= '0;
            rcnt    <= '0;
            rreload <= '0;
        end else if (load) begin
            dcnt    <= dwell_in;
            rcnt    <= rsp_in;
            rreload <= rsp_in;
        end else if (run) begin
            if (rcnt == '0) begin
                rcnt <= rreload;
                dcnt <= dcnt - 1'b1;
            end else begin
                rcnt <= rcnt - 1'b1;
            end
        end
    end

    assign last = (dcnt == '0) && (rcnt == '0);

endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
    import clkseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_start,
    input  logic              run_abort,
    input  seq_word_t         seq_word,
    input  pat_word_t         pat_word,
    input  logic              tmr_last,
    output logic [SEQ_AW-1:0] seq_raddr,
    output logic [PAT_AW-1:0] pat_raddr,
    output logic              tmr_load,
    output logic              tmr_run,
    output logic [RSP_W-1:0]  tmr_rsp,
    output logic [NCLK-1:0]   lv_out,
    output logic              busy,
    output logic              in_play
);
    run_state_t        state;
    logic [SEQ_AW-1:0] seq_ptr;
    logic [PAT_AW-1:0] pat_ptr;
    logic [PAT_AW-1:0] pat_first;
    logic [REP_W-1:0]  rep_left;
    logic [RSP_W-1:0]  rsp_q;
    logic              cur_eop;
    logic [NCLK-1:0]   lv_q;
    logic              busy_q;

    logic fetch_go;
    logic pat_done;
    logic step;

    assign fetch_go = (state == ST_FETCH) && !run_abort && !seq_word.stop;
    assign pat_done = cur_eop && (rep_left == '0);
    assign step     = (state == ST_PLAY) && !run_abort && tmr_last && !pat_done;

    always_comb begin
        unique case (state)
            ST_FETCH: pat_raddr = seq_word.start;
            ST_PLAY:  pat_raddr = follow_addr(cur_eop, pat_ptr, pat_first);
            default:  pat_raddr = pat_ptr;
        endcase
    end

    assign seq_raddr = seq_ptr;
    assign tmr_load  = fetch_go || step;
    assign tmr_run   = (state == ST_PLAY);
    assign tmr_rsp   = (state == ST_FETCH) ? seq_word.rsp : rsp_q;
    assign lv_out    = lv_q;
    assign busy      = busy_q;
    assign in_play   = (state == ST_PLAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            seq_ptr   <= '0;
            pat_ptr   <= '0;
            pat_first <= '0;
            rep_left  <= '0;
            rsp_q     <= '0;
            cur_eop   <= 1'b0;
            lv_q      <= '0;
            busy_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run_start) begin
                        seq_ptr <= '0;
                        busy_q  <= 1'b1;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (run_abort || seq_word.stop) begin
                        busy_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        rsp_q     <= seq_word.rsp;
                        rep_left  <= seq_word.rep;
                        pat_first <= seq_word.start;
                        pat_ptr   <= seq_word.start;
                        lv_q      <= pat_word.lv;
                        cur_eop   <= pat_word.eop;
                        state     <= ST_PLAY;
                    end
                end
                ST_PLAY: begin
                    if (run_abort) begin
                        busy_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else if (tmr_last) begin
                        if (pat_done) begin
                            seq_ptr <= seq_ptr + 1'b1;
                            state   <= ST_FETCH;
                        end else begin
                            pat_ptr <= pat_raddr;
                            lv_q    <= pat_word.lv;
                            cur_eop <= pat_word.eop;
                            if (cur_eop) begin
                                rep_left <= rep_left - 1'b1;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
    import clkseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_start,
    input  logic              run_abort,
    input  logic              pat_wr_en,
    input  logic [PAT_AW-1:0] pat_wr_addr,
    input  logic [PAT_W-1:0]  pat_wr_data,
    input  logic              seq_wr_en,
    input  logic [SEQ_AW-1:0] seq_wr_addr,
    input  logic [SEQ_W-1:0]  seq_wr_data,
    output logic [NCLK-1:0]   clk_lines,
    output logic              busy
);
    logic [SEQ_AW-1:0] seq_raddr;
    logic [PAT_AW-1:0] pat_raddr;
    logic [SEQ_W-1:0]  seq_rdata;
    logic [PAT_W-1:0]  pat_rdata;
    logic              tmr_load;
    logic              tmr_run;
    logic [RSP_W-1:0]  tmr_rsp;
    logic              dwell_done;
    logic              in_play;
    pat_word_t         pat_word;
    seq_word_t         seq_word;

    assign pat_word = pat_word_t'(pat_rdata);
    assign seq_word = seq_word_t'(seq_rdata);

    clkseq_mem #(.AW(PAT_AW), .W(PAT_W)) u_pat (
        .clk     (clk),
        .wr_en   (pat_wr_en && !busy),
        .wr_addr (pat_wr_addr),
        .wr_data (pat_wr_data),
        .rd_addr (pat_raddr),
        .rd_data (pat_rdata)
    );

    clkseq_mem #(.AW(SEQ_AW), .W(SEQ_W)) u_seq (
        .clk     (clk),
        .wr_en   (seq_wr_en && !busy),
        .wr_addr (seq_wr_addr),
        .wr_data (seq_wr_data),
        .rd_addr (seq_raddr),
        .rd_data (seq_rdata)
    );

    clkseq_dwell #(.DW_W(DW_W), .RSP_W(RSP_W)) u_dwell (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .run      (tmr_run),
        .dwell_in (pat_word.dwell),
        .rsp_in   (tmr_rsp),
        .last     (dwell_done)
    );

    clkseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run_start (run_start),
        .run_abort (run_abort),
        .seq_word  (seq_word),
        .pat_word  (pat_word),
        .tmr_last  (dwell_done),
        .seq_raddr (seq_raddr),
        .pat_raddr (pat_raddr),
        .tmr_load  (tmr_load),
        .tmr_run   (tmr_run),
        .tmr_rsp   (tmr_rsp),
        .lv_out    (clk_lines),
        .busy      (busy),
        .in_play   (in_play)
    );

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk
    import clkseq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            run_start,
    input logic            run_abort,
    input logic            busy,
    input logic [NCLK-1:0] clk_lines,
    input logic            in_play,
    input logic            dwell_done
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (clk_lines == '0) && !busy);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (run_start && !busy) |=> busy);

    assert_dwell_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (in_play && !dwell_done && !run_abort) |=> (busy && $stable(clk_lines)));

    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $stable(clk_lines));

    assert_abort_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && run_abort) |=> (!busy && $stable(clk_lines)));

    assert_idle_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(clk_lines));

endmodule

bind clkseq_top clkseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_start  (run_start),
    .run_abort  (run_abort),
    .busy       (busy),
    .clk_lines  (clk_lines),
    .in_play    (in_play),
    .dwell_done (dwell_done)
);

// File: tb/sim_clkseq_top.sv
module sim_clkseq_top;
    import clkseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run_start = 1'b0;
    logic              run_abort = 1'b0;
    logic              pat_wr_en = 1'b0;
    logic [PAT_AW-1:0] pat_wr_addr = '0;
    logic [PAT_W-1:0]  pat_wr_data = '0;
    logic              seq_wr_en = 1'b0;
    logic [SEQ_AW-1:0] seq_wr_addr = '0;
    logic [SEQ_W-1:0]  seq_wr_data = '0;
    logic [NCLK-1:0]   clk_lines;
    logic              busy;

    always #5 clk = ~clk;

    clkseq_top u0 (
        .clk(clk), .rst(rst), .run_start(run_start), .run_abort(run_abort),
        .pat_wr_en(pat_wr_en), .pat_wr_addr(pat_wr_addr), .pat_wr_data(pat_wr_data),
        .seq_wr_en(seq_wr_en), .seq_wr_addr(seq_wr_addr), .seq_wr_data(seq_wr_data),
        .clk_lines(clk_lines), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench-side copies of what was programmed
    logic [NCLK-1:0]  pm_lv  [64];
    logic [DW_W-1:0]  pm_dw  [64];
    logic             pm_eop [64];
    logic [PAT_AW-1:0] sm_start [16];
    logic [REP_W-1:0] sm_rep [16];
    logic [RSP_W-1:0] sm_rsp [16];
    logic             sm_stop [16];

    logic [NCLK-1:0] exp_lv [8192];
    logic            exp_bz [8192];
    int              exp_n;
    logic [NCLK-1:0] cur_lv = '0;

    task automatic check(input string tag, input logic [NCLK-1:0] a_lv, input logic a_bz,
                         input logic [NCLK-1:0] e_lv, input logic e_bz);
        checks++;
        if (a_lv !== e_lv || a_bz !== e_bz) begin
            errors++;
            $display("FAIL %s: lines=%h busy=%b expected lines=%h busy=%b",
                     tag, a_lv, a_bz, e_lv, e_bz);
        end
    endtask

    task automatic put_pat(input int a, input logic [NCLK-1:0] lv, input int dw, input bit eop);
        pat_word_t w;
        pm_lv[a] = lv; pm_dw[a] = DW_W'(dw); pm_eop[a] = eop;
        w.lv = lv; w.dwell = DW_W'(dw); w.eop = eop;
        @(negedge clk);
        pat_wr_en = 1'b1; pat_wr_addr = PAT_AW'(a); pat_wr_data = w;
        @(negedge clk);
        pat_wr_en = 1'b0;
    endtask

    task automatic put_seq(input int a, input int st, input int rep, input int rsp, input bit stop);
        seq_word_t w;
        sm_start[a] = PAT_AW'(st); sm_rep[a] = REP_W'(rep);
        sm_rsp[a] = RSP_W'(rsp); sm_stop[a] = stop;
        w.start = PAT_AW'(st); w.rep = REP_W'(rep); w.rsp = RSP_W'(rsp); w.stop = stop;
        @(negedge clk);
        seq_wr_en = 1'b1; seq_wr_addr = SEQ_AW'(a); seq_wr_data = w;
        @(negedge clk);
        seq_wr_en = 1'b0;
    endtask

    task automatic push(input logic [NCLK-1:0] lv, input logic bz);
        exp_lv[exp_n] = lv; exp_bz[exp_n] = bz; exp_n++;
    endtask

    // Expected per-cycle trace computed from the requirements
    task automatic build_model();
        int ip = 0;
        exp_n = 0;
        push(cur_lv, 1'b1);                     // R2: fetch cycle of address 0
        forever begin
            if (sm_stop[ip]) begin
                push(cur_lv, 1'b0);             // R7
                break;
            end
            for (int r = 0; r <= int'(sm_rep[ip]); r++) begin   // R4
                int a = int'(sm_start[ip]);
                bit e;
                do begin                         // R5
                    cur_lv = pm_lv[a];
                    for (int k = 0; k < (int'(pm_dw[a]) + 1) * (int'(sm_rsp[ip]) + 1); k++)
                        push(cur_lv, 1'b1);      // R3
                    e = pm_eop[a];
                    a = (a + 1) % 64;
                end while (!e);
            end
            push(cur_lv, 1'b1);                  // R6: fetch cycle
            ip = (ip + 1) % 16;
        end
    endtask

    // Runs the program and compares every cycle; abort_at / poke_at < 0 disable
    task automatic run_check(input string tag, input int abort_at, input int poke_at);
        logic [NCLK-1:0] e_lv;
        logic e_bz;
        build_model();
        @(negedge clk); run_start = 1'b1;
        @(negedge clk); run_start = 1'b0;
        for (int i = 0; i < exp_n + 3; i++) begin
            if (abort_at >= 0 && i > abort_at) begin
                e_lv = exp_lv[abort_at]; e_bz = 1'b0;   // R8
            end else if (i < exp_n) begin
                e_lv = exp_lv[i]; e_bz = exp_bz[i];
            end else begin
                e_lv = exp_lv[exp_n-1]; e_bz = 1'b0;    // R11
            end
            check(tag, clk_lines, busy, e_lv, e_bz);
            if (i == abort_at) run_abort = 1'b1;
            if (i == poke_at) begin                      // R9, R10
                run_start = 1'b1;
                pat_wr_en = 1'b1; pat_wr_addr = '0; pat_wr_data = '1;
                seq_wr_en = 1'b1; seq_wr_addr = SEQ_AW'(1); seq_wr_data = '0;
            end
            @(negedge clk);
            run_abort = 1'b0; run_start = 1'b0; pat_wr_en = 1'b0; seq_wr_en = 1'b0;
        end
        if (abort_at >= 0) cur_lv = exp_lv[abort_at];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", clk_lines, busy, '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", clk_lines, busy, '0, 1'b0);

        // Pattern A at 0: three states; B at 8: two states; C at 16: one state; D at 20: max dwell
        for (int a = 0; a < 64; a++) begin
            pm_lv[a] = '0; pm_dw[a] = '0; pm_eop[a] = 1'b1;
        end
        put_pat(0,  18'h15A5A, 0, 1'b0);
        put_pat(1,  18'h2C3C3, 2, 1'b0);
        put_pat(2,  18'h0F00F, 1, 1'b1);
        put_pat(8,  18'h3FFFF, 1, 1'b0);
        put_pat(9,  18'h00001, 0, 1'b1);
        put_pat(16, 18'h24924, 2, 1'b1);
        put_pat(20, 18'h1B6DB, 255, 1'b1);

        // R0-address stop: busy for one fetch cycle only
        put_seq(0, 0, 0, 0, 1'b1);
        run_check("R7 stop at address 0", -1, -1);

        // Sweep of read speed and repeat count over pattern A
        for (int rsp = 0; rsp < 4; rsp++) begin
            for (int rep = 0; rep < 3; rep++) begin
                put_seq(0, 0, rep, rsp, 1'b0);
                put_seq(1, 0, 0, 0, 1'b1);
                run_check("R3 R4 R5 sweep pattern A", -1, -1);
            end
        end

        // One-state pattern swept
        for (int rsp = 0; rsp < 4; rsp++) begin
            put_seq(0, 16, 2, rsp, 1'b0);
            put_seq(1, 0, 0, 0, 1'b1);
            run_check("R5 one-state pattern", -1, -1);
        end

        // Multi-entry program
        put_seq(0, 0, 1, 1, 1'b0);
        put_seq(1, 16, 2, 0, 1'b0);
        put_seq(2, 8, 0, 2, 1'b0);
        put_seq(3, 0, 0, 0, 1'b1);
        run_check("R6 multi-entry program", -1, -1);

        // Writes and start while busy are ignored; same program again after
        run_check("R9 R10 activity while busy", -1, 4);
        run_check("R9 program intact after busy writes", -1, -1);

        // Maximum dwell with read speed 3
        put_seq(0, 20, 0, 3, 1'b0);
        put_seq(1, 0, 0, 0, 1'b1);
        run_check("R3 maximum dwell", -1, -1);

        // Abort in the middle of a play and during the first fetch
        put_seq(0, 0, 2, 2, 1'b0);
        put_seq(1, 0, 0, 0, 1'b1);
        run_check("R8 abort while playing", 7, -1);
        run_check("R8 abort at fetch", 0, -1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule